// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the synchronized levels of a 32-pin GPIO bank into per-pin interrupt status bits and one bank-level interrupt request. The pins form four ports of eight. Each pin has a three-bit trigger setting that selects one of five modes: rising edge, falling edge, both edges, level high or level low. Each pin also has an enable bit and a write-one-to-clear strobe.

Status bits are sticky and can always be observed, whatever the enable. The enable decides only whether a set status bit drives the bank request.

Edge-mode pins keep a new edge even when it lands in the same cycle as a clear. Software can therefore clear a pin first and service it afterwards without missing anything. Level-mode pins report again after a clear if the pin is still at its active level. Register decoding and pad logic belong to the surrounding design.

Top module: `gpio_evt_bank`

## Requirements
- R1: In the first cycle after reset release, every status bit and the bank request are 0. Pin levels that are held constant through and after reset produce no edge event.
- R2: Pin index is port*8 + bit. Port p's trigger word is trig_cfg_i[p*24 +: 24]. Within that word, bit b is the polarity of pin b, bit b+8 selects edge mode, and bit b+16 selects both edges. A mode is written {both, edge, polarity}.
- R3: Mode 011 (rising) sets status on the clock edge where the level is first sampled high after being low. A falling transition does not set it.
- R4: Mode 010 (falling) sets status on a high-to-low transition and ignores a low-to-high transition.
- R5: Mode 110 (both edges) sets status on either transition.
- R6: Mode 001 (level high) sets status in every cycle the pin is sampled high. The status stays set after the pin goes low, until it is cleared.
- R7: Mode 000 (level low) sets status in every cycle the pin is sampled low.
- R8: A clear strobe on a pin with no new edge clears that pin's status on the next clock edge. Other pins' status bits are untouched.
- R9: In edge modes, an edge arriving in the same cycle as a clear leaves the status set. An edge arriving after a clear sets it again.
- R10: In level modes, a clear wins for one cycle. If the pin is still active, the status is set again on the following cycle.
- R11: Status bits set regardless of the pin's enable bit.
- R12: bank_irq_o is registered: it equals the OR of (status AND enable) over all pins as of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pin_lvl_i | input | 32 | Synchronized pin levels |
| trig_cfg_i | input | 96 | Trigger mode planes, 24 bits per port |
| irq_en_i | input | 32 | Per-pin contribution enable |
| clr_i | input | 32 | Per-pin write-one-to-clear strobe |
| status_o | output | 32 | Sticky per-pin status |
| bank_irq_o | output | 1 | Registered bank interrupt request |

## Verification
Each trigger mode is driven with a rising transition, a falling transition and a steady level. This shows which transitions a mode accepts and which it rejects, and it shows sticky behaviour after the pin returns idle.

A clear is applied in three situations:
- alone, to show it removes only its own bit;
- together with a fresh edge, to show that set beats clear in edge modes;
- while a level pin is still active, to show the one-cycle drop and the re-assertion.

The enable is toggled around a set status bit to show that enable gates only the bank request, and to measure its one-cycle latency in both directions.

// File: rtl/gpio_evt_pkg.sv
// Package: shared constants, mode encodings and the trigger decode
// used by the GPIO bank interrupt detector.
// Assumes the three-plane encoding {both, edge, polarity} per pin.
package gpio_evt_pkg;

    localparam int unsigned CFG_PLANES = 3;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'b000,
        TRIG_LVL_HIGH = 3'b001,
        TRIG_FALL     = 3'b010,
        TRIG_RISE     = 3'b011,
        TRIG_BOTH     = 3'b110
    } trig_mode_e;

    typedef struct packed {
        logic edge_mode;
        logic want_rise;
        logic want_fall;
        logic act_high;
    } trig_dec_t;

    // Split a {both, edge, polarity} triple into the controls one pin uses.
    function automatic trig_dec_t trig_decode(input logic [2:0] cfg);
        trig_dec_t d;
        d.edge_mode = cfg[1];
        d.act_high  = cfg[0];
        d.want_rise = cfg[2] | cfg[0];
        d.want_fall = cfg[2] | ~cfg[0];
        return d;
    endfunction

endpackage

// File: rtl/gpio_evt_pin_cell.sv
// Module: one pin's detector.
// Keeps the previous level for edge detection, plus one sticky status bit.
// Assumes lvl_i is already synchronized to clk_i.
// Set beats clear in edge mode. Clear beats set in level mode, which
// makes an active level re-assert on the following cycle.
module gpio_evt_pin_cell
    import gpio_evt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lvl_i,
    input  logic [2:0] cfg_i,
    input  logic       en_i,
    input  logic       clr_i,
    output logic       status_o,
    output logic       req_o
);

    trig_dec_t dec;
    logic      prev_q;
    logic      status_q;
    logic      status_d;
    logic      rise_ev;
    logic      fall_ev;
    logic      edge_hit;
    logic      level_hit;

    // Decode the pin's mode triple.
    always_comb dec = trig_decode(cfg_i);

    // Previous-level register. It also loads during reset, so leaving
    // reset cannot look like an edge.
    always_ff @(posedge clk_i) begin
        prev_q <= lvl_i;
    end

    // Event detection from the current and previous level.
    always_comb begin
        rise_ev   = lvl_i & ~prev_q;
        fall_ev   = ~lvl_i & prev_q;
        edge_hit  = (dec.want_rise & rise_ev) | (dec.want_fall & fall_ev);
        level_hit = (lvl_i == dec.act_high);
    end

    // Next status: sticky set with write-one-to-clear; priority depends on mode.
    always_comb begin
        if (dec.edge_mode) begin
            status_d = edge_hit | (status_q & ~clr_i);
        end else begin
            status_d = ~clr_i & (status_q | level_hit);
        end
    end

    // Status register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            status_q <= 1'b0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;
    assign req_o    = status_q & en_i;

endmodule

// File: rtl/gpio_evt_port.sv
// Module: one port of pin cells.
// Cuts the port's plane-encoded trigger word into per-pin triples and
// ORs the enabled status bits into a single port request.
// Assumes the word layout: polarity at b, edge at b+W, both at b+2W.
module gpio_evt_port
    import gpio_evt_pkg::*;
#(
    parameter int unsigned PINS_PER_PORT = 8
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [PINS_PER_PORT-1:0]            lvl_i,
    input  logic [CFG_PLANES*PINS_PER_PORT-1:0] cfg_word_i,
    input  logic [PINS_PER_PORT-1:0]            en_i,
    input  logic [PINS_PER_PORT-1:0]            clr_i,
    output logic [PINS_PER_PORT-1:0]            status_o,
    output logic                                port_req_o
);

    logic [PINS_PER_PORT-1:0] req;

    // One detector per pin; the triple is gathered across the three planes.
    for (genvar b = 0; b < PINS_PER_PORT; b++) begin : g_pin
        gpio_evt_pin_cell u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .lvl_i    (lvl_i[b]),
            .cfg_i    ({cfg_word_i[b + 2*PINS_PER_PORT],
                        cfg_word_i[b + PINS_PER_PORT],
                        cfg_word_i[b]}),
            .en_i     (en_i[b]),
            .clr_i    (clr_i[b]),
            .status_o (status_o[b]),
            .req_o    (req[b])
        );
    end

    // Port-level request: any enabled status bit in this port.
    assign port_req_o = |req;

endmodule

// File: rtl/gpio_evt_bank.sv
// Module: top of the GPIO bank interrupt detector.
// Instantiates NUM_PORTS ports and registers the OR of their requests.
// Assumes every input is synchronous to clk_i. Reset is synchronous, active low.
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_PORTS     = 4,
    parameter int unsigned PINS_PER_PORT = 8
) (
    input  logic                                          clk_i,
    input  logic                                          rst_ni,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]            pin_lvl_i,
    input  logic [NUM_PORTS*CFG_PLANES*PINS_PER_PORT-1:0] trig_cfg_i,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]            irq_en_i,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]            clr_i,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]            status_o,
    output logic                                          bank_irq_o
);

    localparam int unsigned CFG_W = CFG_PLANES * PINS_PER_PORT;

    logic [NUM_PORTS-1:0] port_req;
    logic                 irq_q;

    // Per-port detectors, each fed its own slice of every vector.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_evt_port #(
            .PINS_PER_PORT (PINS_PER_PORT)
        ) u_port (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .lvl_i      (pin_lvl_i[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .cfg_word_i (trig_cfg_i[p*CFG_W +: CFG_W]),
            .en_i       (irq_en_i[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .clr_i      (clr_i[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .status_o   (status_o[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .port_req_o (port_req[p])
        );
    end

    // Registered bank request.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |port_req;
        end
    end

    assign bank_irq_o = irq_q;

endmodule

// File: rtl/gpio_evt_bank_chk.sv
// Module: assertion checker for gpio_evt_bank, attached with bind.
// It re-derives each pin's mode from the port-level config vector.
module gpio_evt_bank_chk #(
    parameter int unsigned NUM_PORTS     = 4,
    parameter int unsigned PINS_PER_PORT = 8
) (
    input logic                                 clk_i,
    input logic                                 rst_ni,
    input logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_lvl_i,
    input logic [NUM_PORTS*3*PINS_PER_PORT-1:0] trig_cfg_i,
    input logic [NUM_PORTS*PINS_PER_PORT-1:0]   irq_en_i,
    input logic [NUM_PORTS*PINS_PER_PORT-1:0]   clr_i,
    input logic [NUM_PORTS*PINS_PER_PORT-1:0]   status_o,
    input logic                                 bank_irq_o
);

    localparam int unsigned NPIN = NUM_PORTS * PINS_PER_PORT;
    localparam int unsigned CW   = 3 * PINS_PER_PORT;

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        localparam int unsigned P = i / PINS_PER_PORT;
        localparam int unsigned B = i % PINS_PER_PORT;
        logic pol;
        logic edg;
        logic bth;
        assign pol = trig_cfg_i[P*CW + B];
        assign edg = trig_cfg_i[P*CW + PINS_PER_PORT + B];
        assign bth = trig_cfg_i[P*CW + 2*PINS_PER_PORT + B];

        // R3
        rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (edg && !bth && pol && pin_lvl_i[i] && !$past(pin_lvl_i[i])) |=> status_o[i]);

        // R5
        both_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (edg && bth && (pin_lvl_i[i] != $past(pin_lvl_i[i]))) |=> status_o[i]);

        // R8
        clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[i] && (pin_lvl_i[i] == $past(pin_lvl_i[i]))) |=> !status_o[i]);

        // R6
        status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_o[i] && !clr_i[i]) |=> status_o[i]);

        // R10
        level_reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!edg && (pin_lvl_i[i] == pol) && !clr_i[i]) |=> status_o[i]);
    end

    // R12
    bank_irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_irq_o == $past(|(status_o & irq_en_i)));

endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(
    .NUM_PORTS     (NUM_PORTS),
    .PINS_PER_PORT (PINS_PER_PORT)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_lvl_i  (pin_lvl_i),
    .trig_cfg_i (trig_cfg_i),
    .irq_en_i   (irq_en_i),
    .clr_i      (clr_i),
    .status_o   (status_o),
    .bank_irq_o (bank_irq_o)
);

// File: tb/gpio_evt_bank_tb.sv
// Directed bench for gpio_evt_bank: one task per scenario.
module gpio_evt_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lvl = 32'h0;
    logic [95:0] cfg = 96'h0;
    logic [31:0] en = 32'h0;
    logic [31:0] clr = 32'h0;
    logic [31:0] status;
    logic        irq;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    gpio_evt_bank dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pin_lvl_i  (lvl),
        .trig_cfg_i (cfg),
        .irq_en_i   (en),
        .clr_i      (clr),
        .status_o   (status),
        .bank_irq_o (irq)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock; return at the falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R2 layout: port p word at p*24; polarity b, edge b+8, both b+16.
    task automatic set_mode(input int pin, input logic [2:0] mode);
        int p = pin / 8;
        int b = pin % 8;
        cfg[p*24 + b]      = mode[0];
        cfg[p*24 + 8 + b]  = mode[1];
        cfg[p*24 + 16 + b] = mode[2];
    endtask

    // Bring every pin to rising mode, level 0, status 0.
    task automatic quiesce();
        for (int i = 0; i < 32; i++) set_mode(i, 3'b011);
        lvl = 32'h0; en = 32'h0; clr = 32'hFFFF_FFFF;
        cyc(); cyc();
        clr = 32'h0;
        cyc();
        check("R8 quiesce status", status, 32'h0);
    endtask

    task automatic t_reset();
        lvl = 32'hA5A5_0F0F;
        for (int i = 0; i < 32; i++) set_mode(i, 3'b011);
        repeat (5) cyc();
        rst_n = 1'b1;
        cyc();
        check("R1 status after reset", status, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        en = 32'hFFFF_FFFF;
        cyc(); cyc();
        check("R1 no false edge", status, 32'h0);
        check("R1 irq stays low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_rise();
        quiesce();
        lvl[13] = 1'b1; cyc();
        check("R3 rise sets pin13", status, 32'h1 << 13);
        lvl[13] = 1'b0; clr[13] = 1'b1; cyc();
        clr = 32'h0; cyc();
        check("R3 fall ignored", status, 32'h0);
    endtask

    task automatic t_fall();
        quiesce();
        set_mode(20, 3'b010);
        lvl[20] = 1'b1; cyc();
        check("R4 rise ignored", status, 32'h0);
        lvl[20] = 1'b0; cyc();
        check("R4 fall sets pin20", status, 32'h1 << 20);
    endtask

    task automatic t_both();
        quiesce();
        set_mode(31, 3'b110);
        lvl[31] = 1'b1; cyc();
        check("R5 both rise", status, 32'h8000_0000);
        clr[31] = 1'b1; cyc();
        clr = 32'h0;
        check("R5 cleared", status, 32'h0);
        lvl[31] = 1'b0; cyc();
        check("R5 both fall", status, 32'h8000_0000);
    endtask

    task automatic t_level_high();
        quiesce();
        set_mode(0, 3'b001);
        cyc();
        check("R6 low inactive", status, 32'h0);
        lvl[0] = 1'b1; cyc();
        check("R6 high sets", status, 32'h1);
        lvl[0] = 1'b0; cyc();
        check("R6 sticky", status, 32'h1);
        clr[0] = 1'b1; cyc();
        clr = 32'h0;
        check("R6 cleared", status, 32'h0);
    endtask

    task automatic t_level_low();
        quiesce();
        set_mode(9, 3'b000);
        cyc();
        check("R7 low sets", status, 32'h1 << 9);
        lvl[9] = 1'b1; clr[9] = 1'b1; cyc();
        clr = 32'h0; cyc();
        check("R7 high inactive", status, 32'h0);
    endtask

    task automatic t_clear_iso();
        quiesce();
        lvl[6:4] = 3'b111; cyc();
        check("R8 three set", status, 32'h70);
        clr[5] = 1'b1; cyc();
        clr = 32'h0;
        check("R8 only pin5 cleared", status, 32'h50);
    endtask

    task automatic t_edge_race();
        quiesce();
        lvl[7] = 1'b1; cyc();
        lvl[7] = 1'b0; cyc();
        lvl[7] = 1'b1; clr[7] = 1'b1; cyc();
        clr = 32'h0;
        check("R9 set beats clear", status, 32'h80);
        clr[7] = 1'b1; cyc();
        clr = 32'h0;
        check("R9 clear no edge", status, 32'h0);
        lvl[7] = 1'b0; cyc();
        lvl[7] = 1'b1; cyc();
        check("R9 later edge kept", status, 32'h80);
    endtask

    task automatic t_level_clear();
        quiesce();
        set_mode(16, 3'b001);
        lvl[16] = 1'b1; cyc();
        check("R10 set", status, 32'h1 << 16);
        clr[16] = 1'b1; cyc();
        clr = 32'h0;
        check("R10 clear wins", status, 32'h0);
        cyc();
        check("R10 re-asserts", status, 32'h1 << 16);
    endtask

    task automatic t_enable();
        quiesce();
        lvl[25] = 1'b1; cyc();
        check("R11 status without enable", status, 32'h1 << 25);
        cyc();
        check("R12 irq masked", {31'h0, irq}, 32'h0);
        en[25] = 1'b1; cyc();
        check("R12 irq after enable", {31'h0, irq}, 32'h1);
        clr[25] = 1'b1; cyc();
        clr = 32'h0;
        check("R12 irq lags clear", {31'h0, irq}, 32'h1);
        cyc();
        check("R12 irq drops", {31'h0, irq}, 32'h0);
        en = 32'h8; set_mode(3, 3'b001); lvl[3] = 1'b1; cyc(); cyc();
        check("R12 irq from port0", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_level_high();
        t_level_low();
        t_clear_iso();
        t_edge_race();
        t_level_clear();
        t_enable();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule